// File: doc/BRIEF.md
# Request/Acknowledge Parallel I/O Port

This block sits between a processor's register bus and a slow peripheral. It carries bytes in both directions. Each direction uses a request/acknowledge handshake that runs through three phases: idle, data-ready and data-taken. A sender can therefore never replace a value that the receiver has not yet taken.

On the inbound channel, the peripheral raises its request with data on the pins. The port captures the data and reports it as available. Software polls the status, reads the data and then writes a "taken" command. The port acknowledges and keeps the acknowledge high until the peripheral withdraws its request.

On the outbound channel the roles are reversed. A software write starts a request toward the peripheral. The peripheral answers with an acknowledge. The port is reported ready again only once that acknowledge has fallen. Any write made while the outbound channel is busy is discarded, and it sets a sticky overrun flag.

Handshake inputs from the peripheral are resynchronised before use, through a chain of at least two flops.

Top module: `hs_io_port`

## Requirements
- R1: After reset, the status register (address 0) reads in-available (bit 0) = 0, out-ready (bit 1) = 1 and overrun (bit 2) = 0, and both `p_in_ack` and `p_out_req` are low.
- R2: A rising `p_in_req` sets status bit 0 exactly SYNC_STAGES+1 clock edges after the change. The value on `p_in_data` at that edge becomes readable at address 1.
- R3: While status bit 0 is set, changes on `p_in_data` do not alter the value read at address 1.
- R4: Writing bit 0 = 1 to address 3 while status bit 0 is set raises `p_in_ack` and clears status bit 0 on the next edge. `p_in_ack` stays high while `p_in_req` is high. It falls SYNC_STAGES+1 edges after `p_in_req` falls.
- R5: Writing the take command (address 3, bit 0) when no inbound data is available has no effect: `p_in_ack` stays low.
- R6: A write to address 2 while status bit 1 is set drives the written value onto `p_out_data`, raises `p_out_req` and clears status bit 1 on the next edge.
- R7: `p_out_req` and `p_out_data` stay unchanged until `p_out_ack` has been high for SYNC_STAGES+1 edges, after which `p_out_req` falls. Status bit 1 returns to 1 only SYNC_STAGES+1 edges after `p_out_ack` falls.
- R8: A write to address 2 while status bit 1 is clear leaves `p_out_data` unchanged and sets status bit 2. Bit 2 stays set until software writes bit 1 = 1 to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register select: 0 status, 1 inbound data, 2 outbound data, 3 command |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for `cpu_addr` (no read side effects) |
| p_in_req | input | 1 | Peripheral announces inbound data (asynchronous) |
| p_in_data | input | DATA_W | Inbound data from peripheral |
| p_in_ack | output | 1 | Port tells peripheral the data was taken |
| p_out_req | output | 1 | Port announces outbound data |
| p_out_data | output | DATA_W | Outbound data to peripheral |
| p_out_ack | input | 1 | Peripheral reports outbound data taken (asynchronous) |

## Verification
Inbound transfers use random byte values. While a byte is held, the pins are flipped to its complement, which separates a held capture from a transparent path. Outbound transfers use random peripheral response delays, and extra writes arrive both while the request is up and while the acknowledge is still high. These two busy windows show whether the overrun guard covers both non-idle phases or only one. Exact-edge samples just before and just after each synchroniser delay separate a correct delay from a one-flop-short or one-flop-long chain. Out-of-phase take commands confirm that the inbound channel ignores them.

// File: rtl/hs_io_pkg.sv
package hs_io_pkg;

   typedef enum logic [1:0] {
      IN_IDLE  = 2'd0,
      IN_READY = 2'd1,
      IN_TAKEN = 2'd2
   } in_phase_t;

   typedef enum logic [1:0] {
      OUT_IDLE = 2'd0,
      OUT_REQ  = 2'd1,
      OUT_DONE = 2'd2
   } out_phase_t;

   // register map
   localparam logic [1:0] A_STATUS = 2'd0;
   localparam logic [1:0] A_IN     = 2'd1;
   localparam logic [1:0] A_OUT    = 2'd2;
   localparam logic [1:0] A_CMD    = 2'd3;

   // status and command bit positions
   localparam int ST_IN_AVAIL  = 0;
   localparam int ST_OUT_READY = 1;
   localparam int ST_OVERRUN   = 2;
   localparam int CM_TAKE      = 0;
   localparam int CM_CLR_OVR   = 1;
   localparam int STATUS_W     = 3;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan
   import hs_io_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_s,
   input  logic [DATA_W-1:0] pin_data,
   input  logic              take,
   output logic              ack,
   output logic              avail,
   output logic [DATA_W-1:0] hold
);
   in_phase_t phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= IN_IDLE;
         hold  <= '0;
      end else begin
         unique case (phase)
            IN_IDLE: if (req_s) begin
               hold  <= pin_data;
               phase <= IN_READY;
            end
            IN_READY: if (take) phase <= IN_TAKEN;
            IN_TAKEN: if (!req_s) phase <= IN_IDLE;
            default:  phase <= IN_IDLE;
         endcase
      end
   end

   assign ack   = (phase == IN_TAKEN);
   assign avail = (phase == IN_READY);
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan
   import hs_io_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_s,
   output logic              req,
   output logic [DATA_W-1:0] pout_data,
   output logic              ready,
   output logic              reject
);
   out_phase_t phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= OUT_IDLE;
         pout_data <= '0;
      end else begin
         unique case (phase)
            OUT_IDLE: if (wr) begin
               pout_data <= wdata;
               phase     <= OUT_REQ;
            end
            OUT_REQ:  if (ack_s)  phase <= OUT_DONE;
            OUT_DONE: if (!ack_s) phase <= OUT_IDLE;
            default:  phase <= OUT_IDLE;
         endcase
      end
   end

   assign req    = (phase == OUT_REQ);
   assign ready  = (phase == OUT_IDLE);
   assign reject = wr && (phase != OUT_IDLE);
endmodule

// File: rtl/hs_io_port.sv
module hs_io_port
   import hs_io_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cpu_addr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              p_in_req,
   input  logic [DATA_W-1:0] p_in_data,
   output logic              p_in_ack,
   output logic              p_out_req,
   output logic [DATA_W-1:0] p_out_data,
   input  logic              p_out_ack
);
   localparam int PAD_W = DATA_W - STATUS_W;

   generate
      if (DATA_W < STATUS_W) begin : g_bad_w
         $error("hs_io_port: DATA_W too narrow for status");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("hs_io_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              in_req_s, out_ack_s;
   logic              in_avail, out_ready, out_reject;
   logic              take_cmd, clr_ovr, out_wr;
   logic              overrun;
   logic [DATA_W-1:0] in_hold;
   logic [DATA_W-1:0] out_rb;
   logic [STATUS_W-1:0] status_w;

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_in  (.clk(clk), .rst_n(rst_n), .d(p_in_req),  .q(in_req_s));
   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_out (.clk(clk), .rst_n(rst_n), .d(p_out_ack), .q(out_ack_s));

   assign take_cmd = cpu_wr && (cpu_addr == A_CMD) && cpu_wdata[CM_TAKE];
   assign clr_ovr  = cpu_wr && (cpu_addr == A_CMD) && cpu_wdata[CM_CLR_OVR];
   assign out_wr   = cpu_wr && (cpu_addr == A_OUT);

   hs_in_chan #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n), .req_s(in_req_s), .pin_data(p_in_data),
      .take(take_cmd), .ack(p_in_ack), .avail(in_avail), .hold(in_hold)
   );

   hs_out_chan #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .wr(out_wr), .wdata(cpu_wdata),
      .ack_s(out_ack_s), .req(p_out_req), .pout_data(p_out_data),
      .ready(out_ready), .reject(out_reject)
   );

   // sticky overrun: a rejected write wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          overrun <= 1'b0;
      else if (out_reject) overrun <= 1'b1;
      else if (clr_ovr)    overrun <= 1'b0;
   end

   always_comb begin
      status_w = '0;
      status_w[ST_IN_AVAIL]  = in_avail;
      status_w[ST_OUT_READY] = out_ready;
      status_w[ST_OVERRUN]   = overrun;
   end

   generate
      if (OUT_READBACK) begin : g_rb
         assign out_rb = p_out_data;
      end else begin : g_norb
         assign out_rb = '0;
      end
   endgenerate

   always_comb begin
      unique case (cpu_addr)
         A_STATUS: cpu_rdata = {{PAD_W{1'b0}}, status_w};
         A_IN:     cpu_rdata = in_hold;
         A_OUT:    cpu_rdata = out_rb;
         default:  cpu_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hs_io_port_chk.sv
module hs_io_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              p_in_ack,
   input logic              p_out_req,
   input logic [DATA_W-1:0] p_out_data,
   input logic              in_req_s,
   input logic              out_ack_s,
   input logic [DATA_W-1:0] in_hold,
   input logic [2:0]        status_w,
   input logic              clr_ovr,
   input logic              out_reject
);
   // R1
   status_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> status_w == 3'b010);

   // R3
   in_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_w[0] |=> (!status_w[0] || $stable(in_hold)));

   // R4
   in_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_in_ack && in_req_s) |=> p_in_ack);

   // R4
   in_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_in_ack && status_w[0]));

   // R6
   out_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_out_req && status_w[1]));

   // R7
   out_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_w[1] |=> $stable(p_out_data));

   // R7
   out_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_out_req && !out_ack_s) |=> p_out_req);

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_reject |=> status_w[2]);

   // R8
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_w[2] && !clr_ovr) |=> status_w[2]);
endmodule

bind hs_io_port hs_io_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .p_in_ack(p_in_ack), .p_out_req(p_out_req),
   .p_out_data(p_out_data), .in_req_s(in_req_s), .out_ack_s(out_ack_s),
   .in_hold(in_hold), .status_w(status_w), .clr_ovr(clr_ovr),
   .out_reject(out_reject)
);

// File: tb/hs_io_port_bench.sv
module hs_io_port_bench;
   localparam int DW = 8;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cpu_addr = 2'd0;
   logic          cpu_wr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          p_in_req = 1'b0;
   logic [DW-1:0] p_in_data = '0;
   logic          p_in_ack;
   logic          p_out_req;
   logic [DW-1:0] p_out_data;
   logic          p_out_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hs_io_port #(.DATA_W(DW), .SYNC_STAGES(SS)) u_hs_io_port (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .p_in_req(p_in_req),
      .p_in_data(p_in_data), .p_in_ack(p_in_ack), .p_out_req(p_out_req),
      .p_out_data(p_out_data), .p_out_ack(p_out_ack)
   );

   function automatic logic [DW-1:0] exp_status(bit avail, bit ready, bit ovr);
      return {{(DW-3){1'b0}}, ovr, ready, avail};
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(logic [1:0] a, output logic [DW-1:0] v);
      cpu_addr = a;
      #0.5;
      v = cpu_rdata;
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic in_xfer(logic [DW-1:0] v);
      logic [DW-1:0] r;
      p_in_data = v; p_in_req = 1'b1;
      tick(SS);
      rd(2'd0, r); chk("R2 not yet available", r[0], 1'b0);
      tick(1);
      rd(2'd0, r); chk("R2 available", r[0], 1'b1);
      p_in_data = ~v;
      tick(1 + ($urandom % 3));
      rd(2'd1, r); chk("R3 held data", r, v);
      wr(2'd3, 8'h01);
      chk("R4 ack raised", p_in_ack, 1'b1);
      rd(2'd0, r); chk("R4 avail cleared", r[0], 1'b0);
      tick(2 + ($urandom % 4));
      chk("R4 ack held with req", p_in_ack, 1'b1);
      p_in_req = 1'b0;
      tick(SS);
      chk("R4 ack before sync", p_in_ack, 1'b1);
      tick(1);
      chk("R4 ack released", p_in_ack, 1'b0);
   endtask

   task automatic out_xfer(logic [DW-1:0] v, bit extra);
      logic [DW-1:0] r;
      int d;
      wr(2'd2, v);
      chk("R6 req raised", p_out_req, 1'b1);
      chk("R6 data driven", p_out_data, v);
      rd(2'd0, r); chk("R6 ready cleared", r, exp_status(0, 0, 0));
      d = $urandom % 5;
      tick(d);
      if (extra) begin
         wr(2'd2, ~v);
         chk("R8 data unchanged", p_out_data, v);
         rd(2'd0, r); chk("R8 overrun set", r[2], 1'b1);
         tick(2);
         rd(2'd0, r); chk("R8 overrun sticky", r[2], 1'b1);
         wr(2'd3, 8'h02);
         rd(2'd0, r); chk("R8 overrun cleared", r[2], 1'b0);
      end
      chk("R7 req held", p_out_req, 1'b1);
      p_out_ack = 1'b1;
      tick(SS);
      chk("R7 req before sync", p_out_req, 1'b1);
      tick(1);
      chk("R7 req dropped", p_out_req, 1'b0);
      if (extra) begin
         wr(2'd2, v ^ 8'h5a);
         chk("R8 data unchanged in done", p_out_data, v);
         rd(2'd0, r); chk("R8 overrun in done", r[2], 1'b1);
         wr(2'd3, 8'h02);
      end
      tick(2);
      rd(2'd0, r); chk("R7 not ready while ack high", r[1], 1'b0);
      p_out_ack = 1'b0;
      tick(SS);
      rd(2'd0, r); chk("R7 ready before sync", r[1], 1'b0);
      tick(1);
      rd(2'd0, r); chk("R7 ready again", r[1], 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      void'($urandom(32'd1234));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd(2'd0, r); chk("R1 status", r, exp_status(0, 1, 0));
      chk("R1 in ack", p_in_ack, 1'b0);
      chk("R1 out req", p_out_req, 1'b0);
      // R5 take with nothing available
      wr(2'd3, 8'h01);
      tick(2);
      chk("R5 ack stays low", p_in_ack, 1'b0);
      rd(2'd0, r); chk("R5 status unchanged", r, exp_status(0, 1, 0));
      // directed edge values
      in_xfer(8'h00);
      in_xfer(8'hff);
      for (int k = 0; k < 16; k++) in_xfer(DW'($urandom));
      // R5 take after the transfer finished
      wr(2'd3, 8'h01);
      tick(1);
      chk("R5 ack low after idle take", p_in_ack, 1'b0);
      out_xfer(8'ha5, 1'b1);
      for (int k = 0; k < 16; k++) out_xfer(DW'($urandom), k[0]);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule